// File: doc/BRIEF.md
# Dual-Read Register File with Shifting Write Path

This block is the working store of a bit-slice datapath. It holds 32 words of 32 bits. Two read ports, A and B, are addressed independently. Both return data combinationally in the same cycle, so an arithmetic unit outside the block can take two operands from one access. The block has no separate write address. A write always lands in the word that the B address selects, so the B operand's word is the natural destination of a read-modify-write.

The write data does not go straight into the array. It passes through a three-way shifter placed in front of the storage. The shifter takes the external ALU result and writes it unchanged, moved one place toward the MSB, or moved one place toward the LSB. Each shift direction has its own serial input bit that fills the vacated end, and its own serial output that shows the bit pushed out of the other end. Stringing these serial pins across slices, or into an external Q register, supports multiply and divide steps. A write enable and a shift select come from a destination decoder that sits outside the block.

Top module: `dual_read_shift_rf`

## Requirements
- R1: After reset is released, every word reads as zero on both ports until it is written.
- R2: Read port A returns the word at `addr_a` and read port B returns the word at `addr_b`, both combinationally and in the same cycle, for any two addresses.
- R3: When `addr_a` equals `addr_b`, `rd_a` and `rd_b` carry identical data.
- R4: With `wr_en` high, the word selected by `addr_b` takes the shifter output at the rising clock edge, and no other word changes.
- R5: With `shift_sel` at 2'b00, or at the spare code 2'b11, the stored value equals `alu_f` unchanged.
- R6: With `shift_sel` at 2'b01 (up), the stored value is `{alu_f[30:0], up_in}`. `up_out` equals `alu_f[31]` while the code is 2'b01 and is 0 otherwise.
- R7: With `shift_sel` at 2'b10 (down), the stored value is `{dn_in, alu_f[31:1]}`. `dn_out` equals `alu_f[0]` while the code is 2'b10 and is 0 otherwise.
- R8: With `wr_en` low, no word changes, whatever the other inputs are.
- R9: A read of the word being written returns its old contents until the clock edge that performs the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears every word |
| addr_a | input | 5 | Word address for read port A |
| addr_b | input | 5 | Word address for read port B, also the write address |
| wr_en | input | 1 | Write enable from the destination decoder |
| shift_sel | input | 2 | Write-path shift: 00 none, 01 up, 10 down, 11 none |
| alu_f | input | 32 | ALU result that feeds the write shifter |
| up_in | input | 1 | Serial bit that fills bit 0 on an up shift |
| dn_in | input | 1 | Serial bit that fills bit 31 on a down shift |
| up_out | output | 1 | Bit shifted out of the top on an up shift |
| dn_out | output | 1 | Bit shifted out of the bottom on a down shift |
| rd_a | output | 32 | Data from read port A |
| rd_b | output | 32 | Data from read port B |

## Verification
The read ports and the serial outputs are combinational. They are due in the same cycle that their inputs change, so the driver changes inputs on the falling edge and the expected items are compared 2 ns later, before the next rising edge. A write shows up only after that rising edge. Its effect is checked by a read in a later step, and the step that performs the write checks the old data on purpose. The bench keeps a reference array that it updates only after each step has been compared, which keeps the model one edge behind the inputs in the same way as the hardware.

// File: rtl/dual_rf_pkg.sv
package dual_rf_pkg;

   // Shift applied to the ALU result on its way into the array.
   typedef enum logic [1:0] {
      SH_NONE  = 2'b00,
      SH_UP    = 2'b01,
      SH_DOWN  = 2'b10,
      SH_SPARE = 2'b11   // behaves as SH_NONE
   } shift_sel_e;

endpackage

// File: rtl/rf_write_shifter.sv
module rf_write_shifter
   import dual_rf_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  shift_sel_e       mode,
   input  logic [WIDTH-1:0] f_in,
   input  logic             up_in,
   input  logic             dn_in,
   output logic [WIDTH-1:0] wdata,
   output logic             up_out,
   output logic             dn_out
);

   localparam int MSB = WIDTH - 1;

   // Per-bit three-way selection; the end bits take the serial inputs.
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic from_below;
      logic from_above;
      if (i == 0) begin : g_lsb
         assign from_below = up_in;
      end else begin : g_lsb_n
         assign from_below = f_in[i-1];
      end
      if (i == MSB) begin : g_msb
         assign from_above = dn_in;
      end else begin : g_msb_n
         assign from_above = f_in[i+1];
      end
      always_comb begin
         unique case (mode)
            SH_UP:   wdata[i] = from_below;
            SH_DOWN: wdata[i] = from_above;
            default: wdata[i] = f_in[i];
         endcase
      end
   end

   assign up_out = (mode == SH_UP)   ? f_in[MSB] : 1'b0;
   assign dn_out = (mode == SH_DOWN) ? f_in[0]   : 1'b0;

endmodule

// File: rtl/rf_word_array.sv
module rf_word_array #(
   parameter int WORDS = 32,
   parameter int WIDTH = 32,
   localparam int AW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr_a,
   input  logic [AW-1:0]    raddr_b,
   output logic [WIDTH-1:0] rdata_a,
   output logic [WIDTH-1:0] rdata_b
);

   localparam bit FULL_MAP = (WORDS == (1 << AW));

   logic [WIDTH-1:0] mem [WORDS];
   logic             w_hit;

   if (FULL_MAP) begin : g_full
      assign w_hit   = we;
      assign rdata_a = mem[raddr_a];
      assign rdata_b = mem[raddr_b];
   end else begin : g_partial
      // Addresses past the last word read zero and are never written.
      assign w_hit   = we && (int'(waddr) < WORDS);
      assign rdata_a = (int'(raddr_a) < WORDS) ? mem[raddr_a] : '0;
      assign rdata_b = (int'(raddr_b) < WORDS) ? mem[raddr_b] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < WORDS; w++) mem[w] <= '0;
      end else if (w_hit) begin
         mem[waddr] <= wdata;
      end
   end

   // R4: the addressed word holds the presented data after the edge
   a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      w_hit |=> mem[$past(waddr)] == $past(wdata));

   // R8: with the enable low the word on the write address keeps its value
   a_r8_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!we && int'(waddr) < WORDS) |=> mem[$past(waddr)] == $past(mem[waddr]));

   // R3: equal addresses give equal data on both ports
   a_r3_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (raddr_a == raddr_b) |-> (rdata_a == rdata_b));

   // R1: first cycle out of reset every word reads zero
   a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (rdata_a == '0 && rdata_b == '0));

endmodule

// File: rtl/dual_read_shift_rf.sv
module dual_read_shift_rf
   import dual_rf_pkg::*;
#(
   parameter int WORDS = 32,
   parameter int WIDTH = 32,
   localparam int AW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    addr_a,
   input  logic [AW-1:0]    addr_b,
   input  logic             wr_en,
   input  logic [1:0]       shift_sel,
   input  logic [WIDTH-1:0] alu_f,
   input  logic             up_in,
   input  logic             dn_in,
   output logic             up_out,
   output logic             dn_out,
   output logic [WIDTH-1:0] rd_a,
   output logic [WIDTH-1:0] rd_b
);

   if (WIDTH < 2) begin : g_bad_width
      $error("dual_read_shift_rf: WIDTH must be at least 2");
   end
   if (WORDS < 2) begin : g_bad_words
      $error("dual_read_shift_rf: WORDS must be at least 2");
   end

   logic [WIDTH-1:0] shifted;
   shift_sel_e       mode;

   assign mode = shift_sel_e'(shift_sel);

   rf_write_shifter #(.WIDTH(WIDTH)) u_shift (
      .mode   (mode),
      .f_in   (alu_f),
      .up_in  (up_in),
      .dn_in  (dn_in),
      .wdata  (shifted),
      .up_out (up_out),
      .dn_out (dn_out)
   );

   rf_word_array #(.WORDS(WORDS), .WIDTH(WIDTH)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wr_en),
      .waddr   (addr_b),
      .wdata   (shifted),
      .raddr_a (addr_a),
      .raddr_b (addr_b),
      .rdata_a (rd_a),
      .rdata_b (rd_b)
   );

   // R6: serial up output is quiet outside the up mode
   a_r6_up_out_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_sel != 2'b01) |-> !up_out);

   // R7: serial down output is quiet outside the down mode
   a_r7_dn_out_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_sel != 2'b10) |-> !dn_out);

   // R6: an up shift fills bit 0 from the serial input
   a_r6_up_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && shift_sel == 2'b01) |=> rd_b[0] == $past(up_in) || addr_b != $past(addr_b));

   // R7: a down shift fills the top bit from the serial input
   a_r7_dn_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && shift_sel == 2'b10) |=> rd_b[WIDTH-1] == $past(dn_in) || addr_b != $past(addr_b));

endmodule

// File: tb/tb_dual_read_shift_rf.sv
module tb_dual_read_shift_rf;

   localparam int N = 32;
   localparam int W = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [4:0]    addr_a = '0, addr_b = '0;
   logic          wr_en = 1'b0;
   logic [1:0]    shift_sel = 2'b00;
   logic [W-1:0]  alu_f = '0;
   logic          up_in = 1'b0, dn_in = 1'b0;
   logic          up_out, dn_out;
   logic [W-1:0]  rd_a, rd_b;

   dual_read_shift_rf dut (
      .clk(clk), .rst_n(rst_n), .addr_a(addr_a), .addr_b(addr_b),
      .wr_en(wr_en), .shift_sel(shift_sel), .alu_f(alu_f),
      .up_in(up_in), .dn_in(dn_in), .up_out(up_out), .dn_out(dn_out),
      .rd_a(rd_a), .rd_b(rd_b)
   );

   always #5 clk = ~clk;

   typedef struct {
      string        req;
      int           kind;   // 0 rd_a, 1 rd_b, 2 up_out, 3 dn_out
      logic [W-1:0] value;
   } exp_t;

   exp_t         exp_q[$];
   logic [W-1:0] model [N];
   int           compared = 0;
   int           mismatched = 0;
   bit           finished = 1'b0;

   task automatic push(string req, int kind, logic [W-1:0] value);
      exp_t e;
      e.req = req; e.kind = kind; e.value = value;
      exp_q.push_back(e);
   endtask

   // Monitor: pops expected items and compares them with the ports.
   initial begin
      forever begin
         exp_t e;
         logic [W-1:0] got;
         wait (exp_q.size() != 0);
         e = exp_q.pop_front();
         case (e.kind)
            0:       got = rd_a;
            1:       got = rd_b;
            2:       got = {{(W-1){1'b0}}, up_out};
            default: got = {{(W-1){1'b0}}, dn_out};
         endcase
         compared++;
         if (got !== e.value) begin
            mismatched++;
            $display("FAIL %s port%0d got %h expected %h at %0t",
                     e.req, e.kind, got, e.value, $time);
         end
      end
   end

   // Driver: one step per cycle, reads checked before the writing edge.
   task automatic step(string req, int a, int b, bit we, logic [1:0] sel,
                       logic [W-1:0] f, bit ui, bit di);
      logic [W-1:0] nv;
      @(negedge clk);
      addr_a = 5'(a); addr_b = 5'(b); wr_en = we; shift_sel = sel;
      alu_f = f; up_in = ui; dn_in = di;
      #2;
      push(req, 0, model[a]);
      push(req, 1, model[b]);
      push(req, 2, (sel == 2'b01) ? W'(f[W-1]) : '0);
      push(req, 3, (sel == 2'b10) ? W'(f[0]) : '0);
      case (sel)
         2'b01:   nv = {f[W-2:0], ui};
         2'b10:   nv = {di, f[W-1:1]};
         default: nv = f;
      endcase
      wait (exp_q.size() == 0);
      if (we) model[b] = nv;
   endtask

   function automatic logic [W-1:0] pat(int i);
      return (32'h9E37_79B9 * 32'(i + 1)) ^ 32'h5A5A_0F0F;
   endfunction

   initial begin
      for (int i = 0; i < N; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: cleared contents
      for (int i = 0; i < N; i++) step("R1", i, N - 1 - i, 1'b0, 2'b00, 32'hFFFF_FFFF, 1'b0, 1'b0);

      // R4: fill each word through the B address, A elsewhere
      for (int i = 0; i < N; i++) step("R4", (i + 7) % N, i, 1'b1, 2'b00, pat(i), 1'b0, 1'b0);

      // R2: independent simultaneous reads
      for (int i = 0; i < N; i++) step("R2", i, (i * 5 + 3) % N, 1'b0, 2'b00, '0, 1'b0, 1'b0);

      // R3: same address on both ports
      for (int i = 0; i < N; i += 3) step("R3", i, i, 1'b0, 2'b01, pat(i), 1'b1, 1'b0);

      // R5: unshifted writes, normal and spare code
      step("R5", 0, 4, 1'b1, 2'b11, 32'hDEAD_BEEF, 1'b1, 1'b1);
      step("R5", 0, 5, 1'b1, 2'b00, 32'h1234_5678, 1'b1, 1'b1);
      step("R5", 4, 5, 1'b0, 2'b00, '0, 1'b0, 1'b0);

      // R6: up shifts with both serial values
      step("R6", 0, 10, 1'b1, 2'b01, 32'h8000_0001, 1'b1, 1'b0);
      step("R6", 0, 11, 1'b1, 2'b01, 32'h7FFF_FFFE, 1'b0, 1'b1);
      step("R6", 10, 11, 1'b0, 2'b01, 32'hC000_0000, 1'b0, 1'b0);

      // R7: down shifts with both serial values
      step("R7", 0, 12, 1'b1, 2'b10, 32'h8000_0001, 1'b0, 1'b1);
      step("R7", 0, 13, 1'b1, 2'b10, 32'h7FFF_FFFE, 1'b1, 1'b0);
      step("R7", 12, 13, 1'b0, 2'b10, 32'h0000_0003, 1'b0, 1'b0);

      // R8: enable low with every shift code, then a full sweep
      for (int i = 0; i < 8; i++) step("R8", i, i * 3, 1'b0, 2'(i), 32'hFFFF_FFFF, 1'b1, 1'b1);
      for (int i = 0; i < N; i++) step("R8", i, (i + 16) % N, 1'b0, 2'b00, '0, 1'b0, 1'b0);

      // R9: read of the word being written shows old data, new data after
      step("R9", 20, 20, 1'b1, 2'b00, 32'hA5A5_A5A5, 1'b0, 1'b0);
      step("R9", 20, 20, 1'b1, 2'b01, 32'h0F0F_0F0F, 1'b1, 1'b0);
      step("R9", 20, 21, 1'b0, 2'b00, '0, 1'b0, 1'b0);

      // R4: final sweep confirms only addressed words changed
      for (int i = 0; i < N; i++) step("R4", i, (N - 1) - i, 1'b0, 2'b00, '0, 1'b0, 1'b0);

      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         mismatched++;
         $display("FAIL watchdog: run did not complete, got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule